// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This block decides, on request, which of four debug breakpoint slots have hit and what the debug status register should become. Each slot carries an address register and a two-bit kind field taken from the debug control word. An execute-kind slot hits when its address equals the current instruction pointer. A data-kind slot hits when an external address comparator reports a watchpoint hit for that slot. An I/O-kind slot never hits.

The surrounding core pulses `chk_i` once per evaluation. One cycle later the block presents the new status value, a write-enable for the status register and a debug-exception request. The new status keeps every upper bit of the old status. The low bit of each slot is rebuilt from that slot's hit, whether or not the slot is enabled. The write-enable fires when an enabled slot hit or when `force_i` asked for an update. The exception fires only for an enabled hit.

Top module: `dbg_bp_match`

## Requirements
- R1: A slot whose kind field is 2'b00 (execute) hits when its address register equals `ip_i`. It ignores its watchpoint-hit input.
- R2: A slot whose kind field is 2'b01 (data write) or 2'b11 (data read/write) hits when its bit of `wp_hit_i` is 1. It ignores the address comparison.
- R3: A slot whose kind field is 2'b10 (I/O) never hits, whatever its address and watchpoint inputs.
- R4: Bits STAT_W-1..4 of `stat_o` equal those bits of `stat_i`. Bit n (n = 0..3) of `stat_o` equals slot n's hit, enabled or not.
- R5: `stat_we_o` is 1 exactly when at least one slot that hit is enabled, or `force_i` was 1.
- R6: `exc_o` is 1 exactly when at least one slot that hit is enabled. `force_i` alone never raises it.
- R7: Slot n's kind field sits at `ctrl_i` bits 16+4n+1..16+4n. Slot n counts as enabled when `ctrl_i` bit 2n or bit 2n+1 is set.
- R8: The outputs come one clock after a cycle with `chk_i` high. In every cycle not preceded by `chk_i`, `stat_we_o` and `exc_o` are 0 and `stat_o` holds its value.
- R9: While `rst` is high, `stat_o`, `stat_we_o` and `exc_o` are all 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_i | input | 1 | Evaluation strobe |
| force_i | input | 1 | Request a status write even without an enabled hit |
| ip_i | input | ADDR_W | Current instruction pointer |
| bp_addr_i | input | NSLOT*ADDR_W | Slot address registers; slot n at bits n*ADDR_W and up |
| wp_hit_i | input | NSLOT | Per-slot data watchpoint hit from the external comparator |
| ctrl_i | input | CTRL_W | Debug control word (kinds and enables) |
| stat_i | input | STAT_W | Present debug status value |
| stat_o | output | STAT_W | New debug status value |
| stat_we_o | output | 1 | Status write-enable pulse |
| exc_o | output | 1 | Debug exception request pulse |

## Verification
The assertions assume that `stat_i`, `ctrl_i`, `force_i` and the other slot inputs are stable during the cycle in which `chk_i` is sampled. They do not assume that anything holds after that cycle. The bench drives every input on the falling edge and holds it across the rising edge that samples it. It drops `chk_i` on the next falling edge and changes `stat_i` while idle, so the hold property is exercised against inputs that change.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;
  typedef enum logic [1:0] {
    KIND_EXEC = 2'b00,
    KIND_DWR  = 2'b01,
    KIND_IO   = 2'b10,
    KIND_DRW  = 2'b11
  } slot_kind_e;

  localparam int unsigned KIND_BASE   = 16;
  localparam int unsigned KIND_STRIDE = 4;
  localparam int unsigned KIND_W      = 2;
endpackage

// File: rtl/dbgm_ctrl_decode.sv
module dbgm_ctrl_decode
  import dbgm_pkg::*;
#(
  parameter int unsigned NSLOT  = 4,
  parameter int unsigned CTRL_W = 32
) (
  input  logic [CTRL_W-1:0]       ctrl_i,
  output logic [NSLOT*KIND_W-1:0] kinds_o,
  output logic [NSLOT-1:0]        en_o
);
  logic unused_ctrl_bits;
  assign unused_ctrl_bits = ^ctrl_i;

  for (genvar n = 0; n < NSLOT; n++) begin : g_field
    // either of the two enable bits arms the slot
    assign en_o[n] = ctrl_i[2*n] | ctrl_i[2*n+1];
    assign kinds_o[n*KIND_W +: KIND_W] = ctrl_i[KIND_BASE + KIND_STRIDE*n +: KIND_W];
  end
endmodule

// File: rtl/dbgm_slot.sv
module dbgm_slot
  import dbgm_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [KIND_W-1:0] kind_i,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] ip_i,
  input  logic              wp_hit_i,
  output logic              hit_o,
  output logic              armed_o
);
  always_comb begin
    case (kind_i)
      KIND_EXEC:          hit_o = (addr_i == ip_i);
      KIND_DWR, KIND_DRW: hit_o = wp_hit_i;
      default:            hit_o = 1'b0;
    endcase
  end

  assign armed_o = hit_o & en_i;
endmodule

// File: rtl/dbgm_reduce.sv
module dbgm_reduce #(
  parameter int unsigned NSLOT = 4
) (
  input  logic [NSLOT-1:0] armed_i,
  input  logic             force_i,
  output logic             raise_o,
  output logic             write_o
);
  assign raise_o = |armed_i;
  assign write_o = raise_o | force_i;
endmodule

// File: rtl/dbg_bp_match.sv
module dbg_bp_match
  import dbgm_pkg::*;
#(
  parameter int unsigned NSLOT  = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CTRL_W = 32,
  parameter int unsigned STAT_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    chk_i,
  input  logic                    force_i,
  input  logic [ADDR_W-1:0]       ip_i,
  input  logic [NSLOT*ADDR_W-1:0] bp_addr_i,
  input  logic [NSLOT-1:0]        wp_hit_i,
  input  logic [CTRL_W-1:0]       ctrl_i,
  input  logic [STAT_W-1:0]       stat_i,
  output logic [STAT_W-1:0]       stat_o,
  output logic                    stat_we_o,
  output logic                    exc_o
);
  localparam int unsigned KINDS_W = NSLOT * KIND_W;

  logic [KINDS_W-1:0] kinds;
  logic [NSLOT-1:0]   slot_en;
  logic [NSLOT-1:0]   hit;
  logic [NSLOT-1:0]   armed;
  logic               raise;
  logic               write;
  logic [STAT_W-1:0]  stat_nxt;

  dbgm_ctrl_decode #(.NSLOT(NSLOT), .CTRL_W(CTRL_W)) u_dec (
    .ctrl_i  (ctrl_i),
    .kinds_o (kinds),
    .en_o    (slot_en)
  );

  for (genvar n = 0; n < NSLOT; n++) begin : g_slot
    dbgm_slot #(.ADDR_W(ADDR_W)) u_slot (
      .kind_i   (kinds[n*KIND_W +: KIND_W]),
      .en_i     (slot_en[n]),
      .addr_i   (bp_addr_i[n*ADDR_W +: ADDR_W]),
      .ip_i     (ip_i),
      .wp_hit_i (wp_hit_i[n]),
      .hit_o    (hit[n]),
      .armed_o  (armed[n])
    );
  end

  dbgm_reduce #(.NSLOT(NSLOT)) u_red (
    .armed_i (armed),
    .force_i (force_i),
    .raise_o (raise),
    .write_o (write)
  );

  // upper status kept, per-slot bits rebuilt from every hit
  assign stat_nxt = {stat_i[STAT_W-1:NSLOT], hit};

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_o    <= '0;
      stat_we_o <= 1'b0;
      exc_o     <= 1'b0;
    end else begin
      stat_we_o <= chk_i & write;
      exc_o     <= chk_i & raise;
      if (chk_i) stat_o <= stat_nxt;
    end
  end
endmodule

// File: rtl/dbgm_chk.sv
module dbgm_chk
  import dbgm_pkg::*;
#(
  parameter int unsigned NSLOT  = 4,
  parameter int unsigned STAT_W = 32
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     chk_i,
  input logic                     force_i,
  input logic [NSLOT*KIND_W-1:0]  kinds,
  input logic [STAT_W-1:NSLOT]    stat_hi_i,
  input logic [STAT_W-1:0]        stat_o,
  input logic                     stat_we_o,
  input logic                     exc_o
);
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !chk_i |=> (!stat_we_o && !exc_o && $stable(stat_o)));

  p_exc_needs_we_r6: assert property (@(posedge clk) disable iff (rst)
    exc_o |-> stat_we_o);

  p_force_writes_r5: assert property (@(posedge clk) disable iff (rst)
    (chk_i && force_i) |=> stat_we_o);

  p_unforced_we_r5: assert property (@(posedge clk) disable iff (rst)
    (chk_i && !force_i) |=> (stat_we_o == exc_o));

  p_upper_kept_r4: assert property (@(posedge clk) disable iff (rst)
    chk_i |=> (stat_o[STAT_W-1:NSLOT] == $past(stat_hi_i)));

  for (genvar n = 0; n < NSLOT; n++) begin : g_io
    p_io_silent_r3: assert property (@(posedge clk) disable iff (rst)
      (chk_i && kinds[n*KIND_W +: KIND_W] == KIND_IO) |=> !stat_o[n]);
  end
endmodule

bind dbg_bp_match dbgm_chk #(.NSLOT(NSLOT), .STAT_W(STAT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .chk_i     (chk_i),
  .force_i   (force_i),
  .kinds     (kinds),
  .stat_hi_i (stat_i[STAT_W-1:NSLOT]),
  .stat_o    (stat_o),
  .stat_we_o (stat_we_o),
  .exc_o     (exc_o)
);

// File: tb/dbg_bp_match_tb.sv
module dbg_bp_match_tb;
  localparam logic [1:0] KE = 2'b00, KW = 2'b01, KI = 2'b10, KR = 2'b11;
  localparam logic [31:0] A0 = 32'h0000_1000, A1 = 32'h0000_2000,
                          A2 = 32'h0000_3000, A3 = 32'h0000_4000;

  typedef struct packed {
    logic [31:0] ctrl;
    logic [3:0]  wp;
    logic [31:0] ip;
    logic        frc;
    logic [31:0] sin;
    logic [3:0]  es;
    logic        ewe;
    logic        eexc;
  } vec_t;

  function automatic logic [31:0] mk_ctrl(logic [1:0] t0, logic [1:0] t1,
                                          logic [1:0] t2, logic [1:0] t3,
                                          logic [7:0] en);
    logic [31:0] c;
    c = 32'h0;
    c[17:16] = t0; c[21:20] = t1; c[25:24] = t2; c[29:28] = t3;
    c[7:0] = en;
    return c;
  endfunction

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    // R1 R4: execute hit on slot0, not enabled -> recorded, no write
    '{mk_ctrl(KE,KE,KE,KE,8'h00), 4'b0000, A0, 1'b0, 32'hFFFF_FFFF, 4'b0001, 1'b0, 1'b0},
    // R7: local enable bit of slot0
    '{mk_ctrl(KE,KE,KE,KE,8'h01), 4'b0000, A0, 1'b0, 32'h0000_0000, 4'b0001, 1'b1, 1'b1},
    // R7: global enable bit of slot0
    '{mk_ctrl(KE,KE,KE,KE,8'h02), 4'b0000, A0, 1'b0, 32'hA5A5_A5A0, 4'b0001, 1'b1, 1'b1},
    // R5 R7: enabled slot1 did not hit
    '{mk_ctrl(KE,KE,KE,KE,8'h04), 4'b0000, A0, 1'b0, 32'h1111_111F, 4'b0001, 1'b0, 1'b0},
    // R2: data-write slots follow wp; slot0 ignores ip match
    '{mk_ctrl(KW,KW,KW,KW,8'h80), 4'b1010, A0, 1'b0, 32'h8000_0005, 4'b1010, 1'b1, 1'b1},
    // R2 R5 R6: read/write slots hit unenabled, forced write, no exception
    '{mk_ctrl(KR,KR,KR,KR,8'h00), 4'b0101, A1, 1'b1, 32'h0F0F_0F0A, 4'b0101, 1'b1, 1'b0},
    // R3: I/O slots never hit
    '{mk_ctrl(KI,KI,KI,KI,8'hFF), 4'b1111, A2, 1'b0, 32'h0000_000F, 4'b0000, 1'b0, 1'b0},
    // R3 R4 R6: I/O slots, forced write clears low bits, no exception
    '{mk_ctrl(KI,KI,KI,KI,8'hFF), 4'b1111, A2, 1'b1, 32'h1234_567F, 4'b0000, 1'b1, 1'b0},
    // R1 R2 R3 R4: mixed kinds, only I/O slot enabled
    '{mk_ctrl(KE,KW,KI,KR,8'h10), 4'b1111, A0, 1'b0, 32'hDEAD_BEE0, 4'b1011, 1'b0, 1'b0},
    // R6: mixed kinds, slot3 enabled and hit
    '{mk_ctrl(KE,KW,KI,KR,8'h40), 4'b1111, A0, 1'b0, 32'hDEAD_BEE0, 4'b1011, 1'b1, 1'b1},
    // R1: execute slots ignore wp_hit; only slot3 address matches
    '{mk_ctrl(KE,KE,KE,KE,8'h00), 4'b1111, A3, 1'b0, 32'h7777_7770, 4'b1000, 1'b0, 1'b0},
    // R5: nothing matches, all enabled
    '{mk_ctrl(KE,KE,KE,KE,8'hFF), 4'b0000, 32'h0000_5000, 1'b0, 32'h0000_0008, 4'b0000, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        chk_i = 1'b0;
  logic        force_i = 1'b0;
  logic [31:0] ip_i = '0;
  logic [127:0] bp_addr_i;
  logic [3:0]  wp_hit_i = '0;
  logic [31:0] ctrl_i = '0;
  logic [31:0] stat_i = '0;
  logic [31:0] stat_o;
  logic        stat_we_o, exc_o;
  int          n_chk = 0, n_fail = 0;
  logic        done = 1'b0;

  assign bp_addr_i = {A3, A2, A1, A0};
  always #2 clk = ~clk;

  dbg_bp_match u_dut (
    .clk(clk), .rst(rst), .chk_i(chk_i), .force_i(force_i), .ip_i(ip_i),
    .bp_addr_i(bp_addr_i), .wp_hit_i(wp_hit_i), .ctrl_i(ctrl_i),
    .stat_i(stat_i), .stat_o(stat_o), .stat_we_o(stat_we_o), .exc_o(exc_o)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 stat", stat_o, 32'h0);
    check("R9 we", {31'h0, stat_we_o}, 32'h0);
    check("R9 exc", {31'h0, exc_o}, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ctrl_i = VEC[i].ctrl; wp_hit_i = VEC[i].wp; ip_i = VEC[i].ip;
      force_i = VEC[i].frc; stat_i = VEC[i].sin; chk_i = 1'b1;
      @(negedge clk);
      chk_i = 1'b0;
      check($sformatf("R4 stat vec%0d", i), stat_o, {VEC[i].sin[31:4], VEC[i].es});
      check($sformatf("R5 we vec%0d", i), {31'h0, stat_we_o}, {31'h0, VEC[i].ewe});
      check($sformatf("R6 exc vec%0d", i), {31'h0, exc_o}, {31'h0, VEC[i].eexc});
    end

    // R8: one cycle without strobe -> pulses drop, status holds
    held = stat_o;
    stat_i = 32'hFFFF_FFF0; force_i = 1'b1;
    @(negedge clk);
    check("R8 hold stat", stat_o, held);
    check("R8 we low", {31'h0, stat_we_o}, 32'h0);
    check("R8 exc low", {31'h0, exc_o}, 32'h0);

    // R8: enabled hit pulses for exactly one cycle
    ctrl_i = mk_ctrl(KE, KE, KE, KE, 8'h01); ip_i = A0; force_i = 1'b0;
    stat_i = 32'h0000_0000; chk_i = 1'b1;
    @(negedge clk);
    chk_i = 1'b0;
    check("R8 exc pulse", {31'h0, exc_o}, 32'h1);
    @(negedge clk);
    check("R8 exc gone", {31'h0, exc_o}, 32'h0);
    check("R8 stat kept", stat_o, 32'h0000_0001);

    // R9: reset in mid-run clears outputs
    rst = 1'b1;
    @(negedge clk);
    check("R9 stat after rst", stat_o, 32'h0);
    rst = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule